// File: doc/BRIEF.md
# Block Absolute-Difference Accumulator

This engine measures how far apart two equally sized byte arrays are, for example two 16x16 pixel tiles taken from successive video frames. Once started, it steps through every element position, fetches the byte at that position from each of two read-only memories through one shared address, forms the unsigned absolute difference of the pair and adds it into a running total. When every position has been visited, the total is copied into a result register that drives the output, and a one-cycle completion pulse is raised.

The control side runs a small state machine that alternates between a loop test and an accumulate step, so each element costs two clock cycles. The memories are treated as combinational reads: the byte pair for the current address must be valid in the same cycle the read strobe is high. Whatever decision is taken on the result (for instance comparing it against a threshold) lies outside the block.

Top module: `sad_engine`

## Requirements
- R1: After reset, `sadOut` is 0, `done` is 0 and `memRdEn` is 0.
- R2: While idle with `go` low, the engine raises neither `memRdEn` nor `done`.
- R3: The published result is the sum over all element positions of |A[i] - B[i]|, with both bytes taken as unsigned 0..255 and the sum kept 32 bits wide (all-zero against all-255 gives 65280; identical arrays give 0).
- R4: During a run, `memRdEn` is high for exactly one cycle per element, never in two consecutive cycles, and the address presented with the strobes counts upward from 0 to 255 in steps of one, so each position is read exactly once.
- R5: `done` is observed high exactly 2*256+4 clock edges after the edge at which `go` is first sampled high in idle.
- R6: `done` is a single-cycle pulse, and `sadOut` changes only in the cycle `done` is high.
- R7: During a run, `sadOut` keeps the result of the previous run until the new one is loaded.
- R8: Holding `go` high while a run is in progress neither restarts nor delays the run.
- R9: After a run completes with `go` low, the engine stays idle: no further strobes and no further `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start request, sampled while idle |
| memAddr | output | 8 | Shared element address for both memories |
| memRdEn | output | 1 | Read strobe, high when the byte pair is consumed |
| aData | input | 8 | Byte from the first array at `memAddr` |
| bData | input | 8 | Byte from the second array at `memAddr` |
| sadOut | output | 32 | Result register holding the last completed sum |
| done | output | 1 | One-cycle pulse when `sadOut` is loaded |

## Verification
A corrupted index shows at the ports within two cycles, as a strobe whose address is not one above the previous strobe's address, or as a completion that arrives early or late against the fixed 516-edge latency. A corrupted running sum is invisible until the end of a run, where `sadOut` disagrees with the sum the bench computes from its own memory copies; arrays that differ only at position 0 or 255 and the saturating all-0 against all-255 case make off-by-one and truncation faults show in the result. A stuck control state shows either as strobes in consecutive cycles or as a missing or repeated `done`.

// File: rtl/sad_pkg.sv
package sad_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_INIT   = 3'd1,
    S_CHECK  = 3'd2,
    S_ACCUM  = 3'd3,
    S_FINISH = 3'd4
  } sad_state_t;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic idxClr;
    logic idxInc;
    logic sumClr;
    logic sumLoad;
    logic outLoad;
    logic rdEn;
  } sad_ctrl_t;

endpackage

// File: rtl/sad_ctrl.sv
module sad_ctrl
  import sad_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      go,
  input  logic      idxBelowEnd,
  output sad_ctrl_t ctrl
);

  sad_state_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      S_IDLE:   if (go) stateD = S_INIT;
      S_INIT:   stateD = S_CHECK;
      S_CHECK:  stateD = idxBelowEnd ? S_ACCUM : S_FINISH;
      S_ACCUM:  stateD = S_CHECK;
      S_FINISH: stateD = S_IDLE;
      default:  stateD = S_IDLE;
    endcase
  end

  // Moore strobes: a function of the present state only
  always_comb begin
    ctrl = '0;
    unique case (stateQ)
      S_INIT: begin
        ctrl.idxClr = 1'b1;
        ctrl.sumClr = 1'b1;
      end
      S_ACCUM: begin
        ctrl.idxInc  = 1'b1;
        ctrl.sumLoad = 1'b1;
        ctrl.rdEn    = 1'b1;
      end
      S_FINISH: ctrl.outLoad = 1'b1;
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/sad_datapath.sv
module sad_datapath
  import sad_pkg::*;
#(
  parameter int ELEMS  = 256,
  parameter int DATA_W = 8,
  parameter int SUM_W  = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  sad_ctrl_t                  ctrl,
  input  logic [DATA_W-1:0]          aData,
  input  logic [DATA_W-1:0]          bData,
  output logic [$clog2(ELEMS)-1:0]   memAddr,
  output logic                       memRdEn,
  output logic                       idxBelowEnd,
  output logic [SUM_W-1:0]           sadOut,
  output logic                       done
);

  localparam int ADDR_W = $clog2(ELEMS);
  localparam int IDX_W  = ADDR_W + 1;

  logic [IDX_W-1:0]  idxQ;
  logic [SUM_W-1:0]  sumQ;
  logic [SUM_W-1:0]  outQ;
  logic              doneQ;
  logic [DATA_W-1:0] absDiff;

  // unsigned magnitude of the byte difference
  always_comb begin
    if (aData >= bData) absDiff = aData - bData;
    else                absDiff = bData - aData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
    end else if (ctrl.idxClr) begin
      idxQ <= '0;
    end else if (ctrl.idxInc) begin
      idxQ <= idxQ + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumQ <= '0;
    end else if (ctrl.sumClr) begin
      sumQ <= '0;
    end else if (ctrl.sumLoad) begin
      sumQ <= sumQ + SUM_W'(absDiff);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= ctrl.outLoad;
      if (ctrl.outLoad) outQ <= sumQ;
    end
  end

  assign idxBelowEnd = (idxQ < IDX_W'(ELEMS));
  assign memAddr     = idxQ[ADDR_W-1:0];
  assign memRdEn     = ctrl.rdEn;
  assign sadOut      = outQ;
  assign done        = doneQ;

endmodule

// File: rtl/sad_engine.sv
module sad_engine
  import sad_pkg::*;
#(
  parameter int ELEMS  = 256,
  parameter int DATA_W = 8,
  parameter int SUM_W  = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     go,
  output logic [$clog2(ELEMS)-1:0] memAddr,
  output logic                     memRdEn,
  input  logic [DATA_W-1:0]        aData,
  input  logic [DATA_W-1:0]        bData,
  output logic [SUM_W-1:0]         sadOut,
  output logic                     done
);

  sad_ctrl_t ctrl;
  logic      idxBelowEnd;

  sad_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .go          (go),
    .idxBelowEnd (idxBelowEnd),
    .ctrl        (ctrl)
  );

  sad_datapath #(
    .ELEMS  (ELEMS),
    .DATA_W (DATA_W),
    .SUM_W  (SUM_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .aData       (aData),
    .bData       (bData),
    .memAddr     (memAddr),
    .memRdEn     (memRdEn),
    .idxBelowEnd (idxBelowEnd),
    .sadOut      (sadOut),
    .done        (done)
  );

endmodule

// File: rtl/sad_engine_chk.sv
module sad_engine_chk #(
  parameter int ELEMS  = 256,
  parameter int SUM_W  = 32
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [$clog2(ELEMS)-1:0] memAddr,
  input logic                     memRdEn,
  input logic [SUM_W-1:0]         sadOut,
  input logic                     done
);

  localparam int ADDR_W = $clog2(ELEMS);

  // strobes seen since the previous completion
  logic [31:0] rdSeen;
  always_ff @(posedge clk) begin
    if (!rstN)        rdSeen <= '0;
    else if (done)    rdSeen <= memRdEn ? 32'd1 : 32'd0;
    else if (memRdEn) rdSeen <= rdSeen + 32'd1;
  end

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_out_only_on_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sadOut) |-> done);

  p_strobe_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && $past(memRdEn, 2)) |-> (memAddr == $past(memAddr, 2) + ADDR_W'(1)));

  p_all_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (rdSeen == 32'(ELEMS)));

  p_no_strobe_at_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memRdEn);

endmodule

bind sad_engine sad_engine_chk #(
  .ELEMS (ELEMS),
  .SUM_W (SUM_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .memAddr (memAddr),
  .memRdEn (memRdEn),
  .sadOut  (sadOut),
  .done    (done)
);

// File: tb/sad_engine_tb_top.sv
module sad_engine_tb_top;

  localparam int N = 256;
  localparam int LATENCY = 2 * N + 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        go = 1'b0;
  logic [7:0]  memAddr;
  logic        memRdEn;
  logic [7:0]  aData, bData;
  logic [31:0] sadOut;
  logic        done;

  logic [7:0] memA [N];
  logic [7:0] memB [N];

  int errors = 0;
  int checks = 0;
  logic [31:0] prevResult = '0;

  always #2 clk = ~clk;

  assign aData = memA[memAddr];
  assign bData = memB[memAddr];

  sad_engine dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .go      (go),
    .memAddr (memAddr),
    .memRdEn (memRdEn),
    .aData   (aData),
    .bData   (bData),
    .sadOut  (sadOut),
    .done    (done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] refSum();
    logic [31:0] s = '0;
    for (int i = 0; i < N; i++)
      s += (memA[i] >= memB[i]) ? 32'(memA[i] - memB[i]) : 32'(memB[i] - memA[i]);
    return s;
  endfunction

  // kind: 0 random, 1 zero vs full, 2 equal, 3 full vs zero, 4 differ at ends only
  task automatic fill(input int kind);
    for (int i = 0; i < N; i++) begin
      case (kind)
        0: begin memA[i] = 8'($urandom); memB[i] = 8'($urandom); end
        1: begin memA[i] = 8'h00; memB[i] = 8'hFF; end
        2: begin memA[i] = 8'($urandom); memB[i] = memA[i]; end
        3: begin memA[i] = 8'hFF; memB[i] = 8'h00; end
        default: begin
          memA[i] = 8'h40; memB[i] = 8'h40;
          if (i == 0)     memB[i] = 8'h07;
          if (i == N - 1) memA[i] = 8'hC3;
        end
      endcase
    end
  endtask

  // holdGo: number of edges go stays high after it is raised
  task automatic runOnce(input int holdGo, input string tag);
    logic [31:0] exp = refSum();
    int cyc = 0, reads = 0, bad = 0, strobeBad = 0;
    logic lastRd = 1'b0;
    @(negedge clk);
    go = 1'b1;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cyc >= holdGo) go = 1'b0;
      if (memRdEn) begin
        if (memAddr !== 8'(reads)) bad++;
        if (lastRd) strobeBad++;
        reads++;
      end
      lastRd = memRdEn;
      if (done === 1'b1) break;
      if (sadOut !== prevResult) bad++;
      if (cyc > 4 * LATENCY) break;
    end
    check({"R4 address order ", tag}, 32'(bad), 0);
    check({"R4 strobe gap ", tag}, 32'(strobeBad), 0);
    check({"R4 reads ", tag}, 32'(reads), 32'(N));
    check({"R5 latency ", tag}, 32'(cyc), 32'(LATENCY));
    check({"R3 result ", tag}, sadOut, exp);
    prevResult = sadOut;
    @(negedge clk);
    check({"R6 done one cycle ", tag}, 32'(done), 0);
    check({"R6 result held ", tag}, sadOut, exp);
  endtask

  initial begin
    int seen;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 sadOut after reset", sadOut, 0);
    check("R1 done after reset", 32'(done), 0);
    check("R1 memRdEn after reset", 32'(memRdEn), 0);

    seen = 0;
    repeat (6) begin
      @(negedge clk);
      if (memRdEn || done) seen++;
    end
    check("R2 idle without go", 32'(seen), 0);

    fill(0); runOnce(1, "random a");
    fill(1); runOnce(1, "zero vs full");
    check("R3 known extreme value", sadOut, 32'd65280);
    fill(2); runOnce(1, "equal arrays");
    check("R3 equal gives zero", sadOut, 0);
    fill(3); runOnce(1, "full vs zero");
    fill(4); runOnce(1, "ends only");
    check("R3 ends only value", sadOut, 32'd57 + 32'd131);
    fill(0); runOnce(200, "R8 go held busy");
    fill(0); runOnce(LATENCY - 2, "R8 go held near end");

    // R7 was checked every cycle inside each run; R9 below
    seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (memRdEn || done) seen++;
    end
    check("R9 stays idle after run", 32'(seen), 0);
    check("R9 result kept", sadOut, prevResult);

    for (int k = 0; k < 3; k++) begin
      fill(0); runOnce(1 + k, "random tail");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule